// File: doc/BRIEF.md
# Page Staging Write Buffer

This block holds up to one page of bytes between a serial-bus protocol engine and a nonvolatile memory array. The protocol engine first loads a word address, then strobes in data bytes. Each byte lands at the current offset inside the selected page. The offset advances by one and wraps around inside the page, while the page number stays fixed. A per-byte mark records which offsets were filled during the transfer.

When the protocol engine signals the end of the transfer (the stop condition), the block starts a self-timed programming cycle of a fixed, parameterized number of clocks. During that cycle it raises `busy` and walks the page offsets. It drives the array write port once for every marked offset, unless the write-protect input blocks the page. The protected region is either the whole array or its top quarter, chosen by a mode input. While `busy` is high the block ignores every request from the protocol engine. When the cycle ends, the shared address pointer is left one past the last byte received.

Top module: `page_stage_writer`

## Requirements
- R1: A byte strobe stores the byte at the page given by the loaded address and at the current offset (the low log2(PAGE_BYTES) address bits). The offset then rises by one while the upper address bits stay unchanged.
- R2: The offset wraps from PAGE_BYTES-1 back to 0 of the same page.
- R3: When more than PAGE_BYTES bytes arrive in one transfer, a later byte replaces the earlier byte at the same offset, so the last byte received wins.
- R4: The programming cycle writes only the offsets that were filled since the last address load. Every other byte of the page keeps its contents, and the marks are empty after the cycle.
- R5: A commit with at least one staged byte raises `busy` on the next clock and holds it for exactly WR_CYCLES clocks. The array write port is active only while `busy` is high.
- R6: While `busy` is high, address loads, byte strobes and commits have no effect.
- R7: A commit with no staged byte (an address-only transfer) starts no cycle, and `busy` stays low.
- R8: The write-protect input is sampled at the commit. With protect high and `wp_mode`=0 (whole array), the cycle still runs for its full length but writes nothing.
- R9: With protect high and `wp_mode`=1 (top quarter), writing is blocked only when the two top address bits are 2'b11 (1800h-1FFFh for a 13-bit address). A page below that region is written.
- R10: With protect low, a page in any region is written.
- R11: After the cycle, `ptr_out` holds the page number with offset (start offset + byte count) mod PAGE_BYTES.
- R12: After reset, `busy` and `arr_we` are low, `ptr_out` is 0 and no byte is marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Load `addr_in` as the new word address and clear the marks |
| addr_in | input | ADDR_W | Starting word address |
| byte_stb | input | 1 | Stage `byte_in` at the current offset |
| byte_in | input | 8 | Data byte |
| commit | input | 1 | End of transfer; starts the programming cycle |
| wp_in | input | 1 | Write-protect level (low means unprotected) |
| wp_mode | input | 1 | 0: protect the whole array, 1: protect the top quarter |
| busy | output | 1 | Programming cycle in progress |
| arr_we | output | 1 | Array write enable |
| arr_waddr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| ptr_out | output | ADDR_W | Shared address pointer |

## Verification
The hardest situation to reach is a set of requests arriving while the programming cycle runs. A byte strobe that slipped through there would add a mark and move the pointer. Its only visible trace would come one transfer later. The bench therefore fires an address load, a byte and a commit in the middle of a cycle. After the cycle it checks the pointer and the page contents. It then issues a bare commit, which must start no new cycle if the stray byte was truly dropped. Page wrap and overflow are reached by choosing start offsets near the end of a page and sending more than a page of bytes.

// File: rtl/page_buf_pkg.sv
package page_buf_pkg;

    typedef enum logic {
        WP_WHOLE    = 1'b0,
        WP_TOPQUART = 1'b1
    } wp_mode_e;

endpackage

// File: rtl/pg_stage_mem.sv
module pg_stage_mem #(
    parameter int PAGE_BYTES = 32,
    parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [OFF_W-1:0] w_off,
    input  logic [7:0]       w_data,
    input  logic [OFF_W-1:0] r_off,
    output logic [7:0]       r_data,
    output logic             r_mark,
    output logic             any_mark
);

    logic [PAGE_BYTES-1:0][7:0] lane_data;
    logic [PAGE_BYTES-1:0]      lane_mark;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
        logic [7:0] data_d, data_q;
        logic       mark_d, mark_q;

        always_comb begin
            data_d = data_q;
            mark_d = mark_q;
            if (clr) begin
                mark_d = 1'b0;
            end
            if (we && (w_off == OFF_W'(g))) begin
                data_d = w_data;
                mark_d = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q <= '0;
                mark_q <= 1'b0;
            end else begin
                data_q <= data_d;
                mark_q <= mark_d;
            end
        end

        assign lane_data[g] = data_q;
        assign lane_mark[g] = mark_q;
    end

    assign r_data   = lane_data[r_off];
    assign r_mark   = lane_mark[r_off];
    assign any_mark = |lane_mark;

endmodule

// File: rtl/pg_wr_timer.sv
module pg_wr_timer #(
    parameter int WR_CYCLES = 64,
    parameter int CNT_W     = $clog2(WR_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             run,
    output logic             last,
    output logic [CNT_W-1:0] cnt
);

    logic             run_d, run_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign last = run_q && (cnt_q == CNT_W'(WR_CYCLES - 1));

    always_comb begin
        run_d = run_q;
        cnt_d = cnt_q;
        if (!run_q) begin
            if (start) begin
                run_d = 1'b1;
                cnt_d = '0;
            end
        end else if (last) begin
            run_d = 1'b0;
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            run_q <= run_d;
            cnt_q <= cnt_d;
        end
    end

    assign run = run_q;
    assign cnt = cnt_q;

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> $past(cnt_q) == CNT_W'(WR_CYCLES - 1)); // R5

endmodule

// File: rtl/pg_wp_region.sv
module pg_wp_region
    import page_buf_pkg::*;
(
    input  logic       wp_in,
    input  logic       wp_mode,
    input  logic [1:0] top_bits,
    output logic       blocked
);

    always_comb begin
        blocked = 1'b0;
        if (wp_in) begin
            if (wp_mode_e'(wp_mode) == WP_WHOLE) begin
                blocked = 1'b1;
            end else begin
                blocked = (top_bits == 2'b11);
            end
        end
    end

endmodule

// File: rtl/page_stage_writer.sv
module page_stage_writer #(
    parameter int ADDR_W     = 13,
    parameter int PAGE_BYTES = 32,
    parameter int WR_CYCLES  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [7:0]        byte_in,
    input  logic              commit,
    input  logic              wp_in,
    input  logic              wp_mode,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_waddr,
    output logic [7:0]        arr_wdata,
    output logic [ADDR_W-1:0] ptr_out
);

    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int CNT_W = $clog2(WR_CYCLES);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              prot;
    } ctl_t;

    ctl_t st_d, st_q;

    logic             stage_clr, stage_we, tmr_start, tmr_last;
    logic             any_mark, r_mark, blocked, in_window;
    logic [CNT_W-1:0] tmr_cnt;
    logic [7:0]       r_data;

    pg_stage_mem #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (stage_clr),
        .we       (stage_we),
        .w_off    (st_q.ptr[OFF_W-1:0]),
        .w_data   (byte_in),
        .r_off    (tmr_cnt[OFF_W-1:0]),
        .r_data   (r_data),
        .r_mark   (r_mark),
        .any_mark (any_mark)
    );

    pg_wr_timer #(.WR_CYCLES(WR_CYCLES), .CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .run   (busy),
        .last  (tmr_last),
        .cnt   (tmr_cnt)
    );

    pg_wp_region u_wp (
        .wp_in    (wp_in),
        .wp_mode  (wp_mode),
        .top_bits (st_q.ptr[ADDR_W-1:ADDR_W-2]),
        .blocked  (blocked)
    );

    // Next-state logic: requests are accepted only while idle.
    always_comb begin
        st_d      = st_q;
        stage_clr = 1'b0;
        stage_we  = 1'b0;
        tmr_start = 1'b0;
        if (!busy) begin
            if (addr_load) begin
                st_d.ptr  = addr_in;
                stage_clr = 1'b1;
            end else if (byte_stb) begin
                stage_we = 1'b1;
                st_d.ptr[OFF_W-1:0] = st_q.ptr[OFF_W-1:0] + 1'b1;
            end else if (commit && any_mark) begin
                tmr_start = 1'b1;
                st_d.prot = blocked;
            end
        end
        if (tmr_last) begin
            stage_clr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_window = {1'b0, tmr_cnt} < (CNT_W + 1)'(PAGE_BYTES);
    assign arr_we    = busy && in_window && r_mark && !st_q.prot;
    assign arr_waddr = {st_q.ptr[ADDR_W-1:OFF_W], tmr_cnt[OFF_W-1:0]};
    assign arr_wdata = r_data;
    assign ptr_out   = st_q.ptr;

    AST_START_NEEDS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(any_mark) && $past(commit)); // R7
    AST_MARKS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !any_mark); // R4
    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(st_q.ptr)); // R6
    AST_PROT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(st_q.prot)); // R8
    AST_WE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy && r_mark); // R5

endmodule

// File: tb/page_stage_writer_tb.sv
module page_stage_writer_tb;

    localparam int AW  = 13;
    localparam int PB  = 32;
    localparam int WRC = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_load = 1'b0, byte_stb = 1'b0, commit = 1'b0;
    logic          wp_in = 1'b0, wp_mode = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [7:0]    byte_in = '0;
    logic          busy, arr_we;
    logic [AW-1:0] arr_waddr, ptr_out;
    logic [7:0]    arr_wdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] arr [int];
    logic [7:0] exp_arr [int];

    always #10 clk = ~clk;

    page_stage_writer #(.ADDR_W(AW), .PAGE_BYTES(PB), .WR_CYCLES(WRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_stb(byte_stb), .byte_in(byte_in), .commit(commit),
        .wp_in(wp_in), .wp_mode(wp_mode), .busy(busy), .arr_we(arr_we),
        .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .ptr_out(ptr_out)
    );

    always @(posedge clk) if (arr_we) arr[int'(arr_waddr)] = arr_wdata;

    function automatic logic [7:0] rd_arr(int a);
        return arr.exists(a) ? arr[a] : 8'hEE;
    endfunction
    function automatic logic [7:0] rd_exp(int a);
        return exp_arr.exists(a) ? exp_arr[a] : 8'hEE;
    endfunction

    task automatic chk(string req, logic ok, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic chk_page(string req, int base);
        int bad_off = -1;
        for (int o = 0; o < PB; o++)
            if (bad_off < 0 && rd_arr(base + o) !== rd_exp(base + o)) bad_off = o;
        if (bad_off < 0) chk(req, 1'b1, 0, 0);
        else chk(req, 1'b0, int'(rd_arr(base + bad_off)), int'(rd_exp(base + bad_off)));
    endtask

    task automatic do_load(logic [AW-1:0] a);
        @(negedge clk); addr_in = a; addr_load = 1'b1;
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic do_byte(logic [7:0] b);
        @(negedge clk); byte_in = b; byte_stb = 1'b1;
        @(negedge clk); byte_stb = 1'b0;
    endtask

    task automatic do_commit(output int cycles);
        @(negedge clk); commit = 1'b1;
        @(negedge clk); commit = 1'b0;
        cycles = 0;
        while (busy) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    // {addr[12:0], count[5:0], wp, mode, seed[7:0]}
    localparam logic [28:0] VEC [0:7] = '{
        {13'h0010, 6'd4,  1'b0, 1'b0, 8'h10},  // R1 R10 plain write
        {13'h013C, 6'd8,  1'b0, 1'b0, 8'h20},  // R2 wrap inside page
        {13'h0200, 6'd40, 1'b0, 1'b0, 8'h40},  // R3 overflow overwrites
        {13'h0405, 6'd3,  1'b1, 1'b0, 8'h70},  // R8 whole array protected
        {13'h0A00, 6'd3,  1'b1, 1'b1, 8'h80},  // R9 below top quarter
        {13'h1820, 6'd3,  1'b1, 1'b1, 8'h90},  // R9 inside top quarter
        {13'h1FFE, 6'd5,  1'b0, 1'b1, 8'hA0},  // R2 R10 wrap at array top
        {13'h0300, 6'd0,  1'b0, 1'b0, 8'h00}   // R7 address-only
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        chk("R12 busy after reset", busy === 1'b0, int'(busy), 0);
        chk("R12 we after reset", arr_we === 1'b0, int'(arr_we), 0);
        chk("R12 ptr after reset", ptr_out === '0, int'(ptr_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 no mark after reset: bare commit starts nothing
        do_commit(cyc);
        chk("R12 empty marks after reset", cyc == 0, cyc, 0);

        for (int v = 0; v < 8; v++) begin
            logic [AW-1:0] a    = VEC[v][28:16];
            int            n    = int'(VEC[v][15:10]);
            logic          wp   = VEC[v][9];
            logic          md   = VEC[v][8];
            logic [7:0]    seed = VEC[v][7:0];
            int            base = int'(a) & ~(PB - 1);
            int            off0 = int'(a) & (PB - 1);
            logic          blk  = wp && (!md || a[AW-1:AW-2] == 2'b11);
            wp_in = wp; wp_mode = md;
            do_load(a);
            for (int i = 0; i < n; i++) begin
                do_byte(seed + 8'(i));
                if (!blk) exp_arr[base + ((off0 + i) % PB)] = seed + 8'(i);
            end
            do_commit(cyc);
            chk($sformatf("R5 R7 busy length vec%0d", v), cyc == (n > 0 ? WRC : 0),
                cyc, (n > 0 ? WRC : 0));
            chk_page($sformatf("R1 R2 R3 R4 R8 R9 R10 page vec%0d", v), base);
            chk($sformatf("R11 ptr vec%0d", v),
                int'(ptr_out) == base + ((off0 + n) % PB), int'(ptr_out),
                base + ((off0 + n) % PB));
        end

        // R6: requests during the programming cycle are dropped
        wp_in = 1'b0;
        do_load(13'h0500);
        do_byte(8'h55); exp_arr[13'h0500] = 8'h55;
        do_byte(8'h56); exp_arr[13'h0501] = 8'h56;
        @(negedge clk); commit = 1'b1;
        @(negedge clk); commit = 1'b0;
        repeat (3) @(negedge clk);
        addr_in = 13'h0700; addr_load = 1'b1;
        @(negedge clk); addr_load = 1'b0; byte_in = 8'hAA; byte_stb = 1'b1;
        @(negedge clk); byte_stb = 1'b0; commit = 1'b1;
        @(negedge clk); commit = 1'b0;
        while (busy) @(negedge clk);
        chk("R6 ptr unchanged by requests in cycle", ptr_out === 13'h0502,
            int'(ptr_out), 32'h0502);
        chk_page("R6 page without stray byte", 13'h0500);
        do_commit(cyc);
        chk("R6 R7 stray byte left no mark", cyc == 0, cyc, 0);
        chk_page("R6 other page untouched", 13'h0700);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule